// File: doc/BRIEF.md
# Masked Pattern Match Event Detector

This block watches one bus sample on every clock edge and raises a one-cycle event when the sample, seen through a programmable bit mask, equals a programmed pattern. A sequence mode holds a second pattern/mask pair. In that mode the event fires only when a match on the second pair follows a match on the first pair within a programmed number of cycles.

An invert option reverses both comparisons, so the block reacts to a mismatch instead of a match. All patterns, masks, the mode bits and the timeout load at run time through a simple write port. Each instance has no shared state, so one instance can sit on each monitored interface and all of them run at the same time. Besides the event pulse, a sticky hit flag records that at least one event has occurred, and software clears it with a write.

Top module: `pattern_event_detector`

## Requirements
- R1: After reset, `event_o` and `hit_o` are low. Every register is zero, which includes the enable bit (CTRL bit 0).
- R2: While CTRL bit 0 (enable) is zero, `event_o` stays low for any sample.
- R3: Single mode (CTRL bit 1 = 0). A channel matches when ((sample XOR pattern) AND mask) is zero. Channel A uses address 0 for the pattern and address 1 for the mask. When channel A matches in the cycle of clock edge k, `event_o` is high for exactly the cycle after edge k.
- R4: Sample bits whose mask bit is zero never affect the result. An all-zero mask matches on every cycle.
- R5: With CTRL bit 2 (invert) set, each channel's condition is true on a mismatch and false on a match.
- R6: Sequence mode (CTRL bit 1 = 1). A condition on channel A arms the sequencer. Channel B uses address 2 for the pattern and address 3 for the mask. A channel B condition fires the event if it occurs 1 to TIMEOUT+1 cycles after the arming sample. TIMEOUT is at address 5.
- R7: In sequence mode, if no channel B condition arrives within that window, the sequencer returns to idle. A channel B condition on its own never fires an event.
- R8: `hit_o` goes high with the first event and stays high. A write to CTRL (address 4) with bit 3 set clears it.
- R9: A write to any register returns the sequencer to idle. No event is produced from the sample of the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| sample | input | DATA_W | Monitored bus value, compared every cycle |
| event_o | output | 1 | Registered one-cycle event pulse |
| hit_o | output | 1 | Sticky flag, set by any event |

## Verification
The bench builds the block with DATA_W = 16 and TMO_W = 4. At that width, full, partial and empty masks can all be written out as readable hex values. The small timeout field keeps the sequence window to a few cycles. This lets the bench place a channel B sample exactly on the last accepted cycle and one cycle past it. It can also place a register write between the arming sample and the closing sample.

// File: rtl/ped_pkg.sv
package ped_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PAT_A  = 3'd0,
    REG_MASK_A = 3'd1,
    REG_PAT_B  = 3'd2,
    REG_MASK_B = 3'd3,
    REG_CTRL   = 3'd4,
    REG_TMO    = 3'd5
  } ped_reg_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEQ_BIT = 1;
  localparam int CTRL_INV_BIT = 2;
  localparam int CTRL_CLR_BIT = 3;

  typedef struct packed {
    logic enable;
    logic seq_mode;
    logic invert;
  } ped_ctrl_t;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_ARMED = 1'b1
  } ped_seq_e;
endpackage

// File: rtl/ped_cfg_regs.sv
module ped_cfg_regs
  import ped_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8,
  parameter int NCH    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NCH-1:0][DATA_W-1:0]  pat,
  output logic [NCH-1:0][DATA_W-1:0]  mask,
  output ped_ctrl_t                   ctrl,
  output logic [TMO_W-1:0]            tmo,
  output logic                        hit_clr
);
  // Per-channel pattern and mask registers, addresses 2*ch and 2*ch+1
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic pat_we, mask_we;
    assign pat_we  = wr_en && (wr_addr == ADDR_W'(2*ch));
    assign mask_we = wr_en && (wr_addr == ADDR_W'(2*ch + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat[ch]  <= '0;
        mask[ch] <= '0;
      end else begin
        if (pat_we)  pat[ch]  <= wr_data;
        if (mask_we) mask[ch] <= wr_data;
      end
    end
  end

  logic ctrl_we, tmo_we;
  assign ctrl_we = wr_en && (wr_addr == REG_CTRL);
  assign tmo_we  = wr_en && (wr_addr == REG_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      tmo  <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl.enable   <= wr_data[CTRL_EN_BIT];
        ctrl.seq_mode <= wr_data[CTRL_SEQ_BIT];
        ctrl.invert   <= wr_data[CTRL_INV_BIT];
      end
      if (tmo_we) tmo <= wr_data[TMO_W-1:0];
    end
  end

  assign hit_clr = ctrl_we && wr_data[CTRL_CLR_BIT];
endmodule

// File: rtl/ped_match.sv
module ped_match #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] mask,
  input  logic              invert,
  output logic              cond
);
  logic [DATA_W-1:0] diff;
  logic              equal;

  always_comb begin
    diff  = (sample ^ pattern) & mask;
    equal = (diff == '0);
    cond  = equal ^ invert;
  end
endmodule

// File: rtl/ped_seq.sv
module ped_seq
  import ped_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             seq_mode,
  input  logic             restart,
  input  logic             cond_a,
  input  logic             cond_b,
  input  logic [TMO_W-1:0] tmo,
  output logic             fire,
  output logic             armed
);
  ped_seq_e         state_q, state_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    fire    = 1'b0;
    if (restart || !enable) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (!seq_mode) begin
      state_d = SQ_IDLE;
      fire    = cond_a;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (cond_a) begin
            state_d = SQ_ARMED;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        SQ_ARMED: begin
          if (cond_b) begin
            fire    = 1'b1;
            state_d = SQ_IDLE;
          end else if (cnt_q == tmo) begin
            state_d = SQ_IDLE;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign armed = (state_q == SQ_ARMED);
endmodule

// File: rtl/pattern_event_detector.sv
module pattern_event_detector
  import ped_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] sample,
  output logic              event_o,
  output logic              hit_o
);
  localparam int NCH = 2;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [NCH-1:0][DATA_W-1:0] pat, mask;
  ped_ctrl_t                  ctrl;
  logic [TMO_W-1:0]           tmo;
  logic                       hit_clr;
  logic [NCH-1:0]             cond;
  logic                       fire, armed;

  ped_cfg_regs #(.DATA_W(DATA_W), .TMO_W(TMO_W), .NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .pat     (pat),
    .mask    (mask),
    .ctrl    (ctrl),
    .tmo     (tmo),
    .hit_clr (hit_clr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    ped_match #(.DATA_W(DATA_W)) u_match (
      .sample  (sample),
      .pattern (pat[ch]),
      .mask    (mask[ch]),
      .invert  (ctrl.invert),
      .cond    (cond[ch])
    );
  end

  ped_seq #(.TMO_W(TMO_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .enable   (ctrl.enable),
    .seq_mode (ctrl.seq_mode),
    .restart  (cfg_we),
    .cond_a   (cond[0]),
    .cond_b   (cond[1]),
    .tmo      (tmo),
    .fire     (fire),
    .armed    (armed)
  );

  logic event_d, hit_d;
  always_comb begin
    event_d = fire;
    hit_d   = hit_o;
    if (hit_clr)   hit_d = 1'b0;
    else if (fire) hit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      event_o <= 1'b0;
      hit_o   <= 1'b0;
    end else begin
      event_o <= event_d;
      hit_o   <= hit_d;
    end
  end

  // Flat copies for the bound checker
  logic              chk_en, chk_seq, chk_inv;
  logic [DATA_W-1:0] chk_pat_a, chk_mask_a;
  assign chk_en     = ctrl.enable;
  assign chk_seq    = ctrl.seq_mode;
  assign chk_inv    = ctrl.invert;
  assign chk_pat_a  = pat[0];
  assign chk_mask_a = mask[0];
endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] sample,
  input logic              event_o,
  input logic              hit_o,
  input logic              en,
  input logic              seq,
  input logic              inv,
  input logic [DATA_W-1:0] pat_a,
  input logic [DATA_W-1:0] mask_a,
  input logic              armed
);
  logic cond_a_ref, clr_req;
  assign cond_a_ref = ((((sample ^ pat_a) & mask_a) == '0) ^ inv);
  assign clr_req    = cfg_we && (cfg_addr == 3'd4) && cfg_wdata[3];

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !event_o);

  // R3
  single_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seq && !cfg_we) |=> (event_o == $past(cond_a_ref)));

  // R7
  seq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq && !armed) |=> !event_o);

  // R8
  hit_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> hit_o);

  // R8
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !clr_req) |=> hit_o);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!event_o && !armed));
endmodule

bind pattern_event_detector ped_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .sample    (sample),
  .event_o   (event_o),
  .hit_o     (hit_o),
  .en        (chk_en),
  .seq       (chk_seq),
  .inv       (chk_inv),
  .pat_a     (chk_pat_a),
  .mask_a    (chk_mask_a),
  .armed     (armed)
);

// File: tb/pattern_event_detector_test.sv
`timescale 1ns/1ps
module pattern_event_detector_test;
  localparam int DW = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] sample = '0;
  logic          event_o, hit_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pattern_event_detector #(.DATA_W(DW), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sample(sample), .event_o(event_o), .hit_o(hit_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One write cycle; sample held at zero
  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; sample = '0;
    @(posedge clk); #1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Present one sample; return after the edge that registers its event
  task automatic step(logic [DW-1:0] s);
    @(negedge clk);
    sample = s;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1;
    check("R1 event after reset", event_o, 1'b0);
    check("R1 hit after reset", hit_o, 1'b0);
  endtask

  task automatic t_disabled;
    step(16'h0000); check("R2 disabled zero mask", event_o, 1'b0);
    step(16'hBEEF); check("R2 disabled any sample", event_o, 1'b0);
  endtask

  task automatic t_single;
    wr(3'd0, 16'h1234); wr(3'd1, 16'hFFFF); wr(3'd4, 16'h0001);
    step(16'h1234); check("R3 exact match", event_o, 1'b1);
    step(16'h1235); check("R3 mismatch", event_o, 1'b0);
    step(16'h1234); check("R3 match again", event_o, 1'b1);
  endtask

  task automatic t_mask;
    wr(3'd0, 16'h0034); wr(3'd1, 16'h00FF);
    step(16'hAB34); check("R4 masked high bits ignored", event_o, 1'b1);
    step(16'h5534); check("R4 other high bits", event_o, 1'b1);
    step(16'hAB35); check("R4 unmasked bit differs", event_o, 1'b0);
    wr(3'd1, 16'h0000);
    step(16'h9999); check("R4 zero mask matches", event_o, 1'b1);
    step(16'h0001); check("R4 zero mask next cycle", event_o, 1'b1);
  endtask

  task automatic t_invert;
    wr(3'd0, 16'h1234); wr(3'd1, 16'hFFFF); wr(3'd4, 16'h0005);
    step(16'h1234); check("R5 invert on match", event_o, 1'b0);
    step(16'h0000); check("R5 invert on mismatch", event_o, 1'b1);
  endtask

  task automatic t_hit;
    wr(3'd4, 16'h0000);
    check("R9 no event after write", event_o, 1'b0);
    check("R8 hit stays set", hit_o, 1'b1);
    step(16'h0000); check("R8 hit still set", hit_o, 1'b1);
    wr(3'd4, 16'h0008);
    check("R8 hit cleared", hit_o, 1'b0);
  endtask

  task automatic t_seq;
    wr(3'd0, 16'h1111); wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'h2222); wr(3'd3, 16'hFFFF);
    wr(3'd5, 16'h0002); wr(3'd4, 16'h0003);
    step(16'h1111); check("R6 arm gives no event", event_o, 1'b0);
    step(16'h2222); check("R6 B right after A", event_o, 1'b1);
    step(16'h2222); check("R7 B alone", event_o, 1'b0);
    step(16'h1111); step(16'h0000); step(16'h0000);
    step(16'h2222); check("R6 B on last window cycle", event_o, 1'b1);
    step(16'h1111); step(16'h0000); step(16'h0000); step(16'h0000);
    step(16'h2222); check("R7 B after timeout", event_o, 1'b0);
  endtask

  task automatic t_restart;
    step(16'h1111);
    wr(3'd5, 16'h0002);
    step(16'h2222); check("R9 write resets sequencer", event_o, 1'b0);
    wr(3'd4, 16'h0001); wr(3'd1, 16'h0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 16'h0000; sample = 16'h1111;
    @(posedge clk); #1;
    check("R9 write cycle sample gives no event", event_o, 1'b0);
    @(negedge clk); cfg_we = 1'b0;
    @(posedge clk); #1;
    check("R3 zero mask after write", event_o, 1'b1);
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", event_o | hit_o, 1'b0);
    t_disabled;
    t_single;
    t_mask;
    t_invert;
    t_hit;
    t_seq;
    t_restart;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule